// File: doc/BRIEF.md
# System Quiesce Lock Controller

A central controller that lets exactly one of several agents perform a system-wide atomic operation at a time. An agent raises its lock request line and keeps it raised. The controller accepts one requester, tells every other agent (DMA engines among them) to stop starting new transactions, and gathers an acknowledge from each one. Only then does it pulse a grant back to the requester.

The requester performs its atomic operation and raises its unlock line. The controller then withdraws the halt, asks every other agent to resume, and waits for each to confirm before it accepts the next lock. If the halted agents do not all acknowledge within a fixed number of cycles, the controller abandons the attempt. It flags the abort, withholds the grant and goes straight to the resume phase.

Top module: `qlk_quiesce_ctrl`

## Requirements
- R1: After synchronous reset, grant_o, halt_o, release_o and abort_o are all zero and the controller is idle.
- R2: One cycle after a lock request is accepted, halt_o is high on every bit except the requester's bit.
- R3: The grant is issued in the cycle after every halted agent has acknowledged, counted over all cycles since the request was accepted. The requester never has to acknowledge itself.
- R4: grant_o is a pulse exactly one cycle long. It is set only on the bit of the accepted requester.
- R5: Among simultaneous requests, the lowest-numbered agent wins. A loser that keeps its request raised is accepted once the controller is idle again.
- R6: While the lock is held, halt_o stays on all other agents until the owner raises its own unlock bit. Unlock bits from other agents have no effect.
- R7: One cycle after the owner's unlock, halt_o is zero and release_o is high on every bit except the owner's. release_o stays high until every such agent has asserted release_ack_i, and the controller is idle in the following cycle.
- R8: Lock requests are ignored while the controller is not idle. They neither change the owner nor produce a grant.
- R9: If the acknowledges are still incomplete after TIMEOUT_CYCLES cycles of waiting, abort_o pulses for one cycle. In that same cycle release_o is raised to the other agents, and no grant is ever issued for that request.
- R10: An acknowledge counts once it has been seen. An agent that acknowledges and then drops its acknowledge before the others answer still counts as acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req_i | input | N_AGENTS | Per-agent lock request, level, held until granted |
| unlock_i | input | N_AGENTS | Per-agent unlock request; only the owner's bit is used |
| grant_o | output | N_AGENTS | One-cycle grant pulse to the lock owner |
| halt_o | output | N_AGENTS | Per-agent instruction to stop starting new transactions |
| halt_ack_i | input | N_AGENTS | Per-agent acknowledge that it has stopped |
| release_o | output | N_AGENTS | Per-agent indication that transactions may resume |
| release_ack_i | input | N_AGENTS | Per-agent acknowledge of the resume |
| abort_o | output | 1 | One-cycle pulse when the acknowledge window expires |

## Verification
The hardest situations to reach are a partial set of acknowledges that must still count later, and a stop phase that runs out of time. The bench models the agents as masks applied to halt_o and release_o. A directed sequence lets one agent acknowledge for a single cycle and withdraw it, and only afterwards raises the rest, so the grant depends on the remembered bit. Table rows with a masked-off agent hold the controller in its stop phase until the window expires. The bench counts those cycles exactly. A held-off release mask likewise keeps the resume phase open while a competing request waits.

// File: rtl/qlk_pkg.sv
package qlk_pkg;

    typedef enum logic [1:0] {
        QS_IDLE     = 2'd0,
        QS_STOPPING = 2'd1,
        QS_LOCKED   = 2'd2,
        QS_RESUMING = 2'd3
    } qstate_e;

    // true for the two phases in which acknowledges are being gathered
    function automatic logic collects_acks(qstate_e s);
        return (s == QS_STOPPING) || (s == QS_RESUMING);
    endfunction

    // true while the other agents must stay quiet
    function automatic logic is_quiesced(qstate_e s);
        return (s == QS_STOPPING) || (s == QS_LOCKED);
    endfunction

endpackage

// File: rtl/qlk_prio_pick.sv
module qlk_prio_pick #(
    parameter int N_AGENTS = 4,
    localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0] req,
    output logic                found,
    output logic [IW-1:0]       idx
);
    // lowest index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/qlk_ack_gather.sv
module qlk_ack_gather #(
    parameter int N_AGENTS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [N_AGENTS-1:0] seed,
    input  logic                enable,
    input  logic [N_AGENTS-1:0] ack,
    output logic                all_in
);
    logic [N_AGENTS-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= '0;
        else if (clear)  seen_q <= seed;
        else if (enable) seen_q <= seen_q | ack;
    end

    assign all_in = &(seen_q | ack);
endmodule

// File: rtl/qlk_stop_timer.sv
module qlk_stop_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)              cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q >= CW'(LIMIT - 1));
endmodule

// File: rtl/qlk_quiesce_ctrl.sv
module qlk_quiesce_ctrl
    import qlk_pkg::*;
#(
    parameter int N_AGENTS       = 4,
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_AGENTS-1:0] lock_req_i,
    input  logic [N_AGENTS-1:0] unlock_i,
    output logic [N_AGENTS-1:0] grant_o,
    output logic [N_AGENTS-1:0] halt_o,
    input  logic [N_AGENTS-1:0] halt_ack_i,
    output logic [N_AGENTS-1:0] release_o,
    input  logic [N_AGENTS-1:0] release_ack_i,
    output logic                abort_o
);
    localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    qstate_e             state_q, state_d;
    logic [IW-1:0]       owner_q, owner_d;
    logic [N_AGENTS-1:0] owner_oh, seed_oh;
    logic [N_AGENTS-1:0] grant_q, grant_d;
    logic                abort_q, abort_d;
    logic                pick_found;
    logic [IW-1:0]       pick_idx;
    logic                gather_clr, all_in, expired;
    logic [N_AGENTS-1:0] ack_sel;

    qlk_prio_pick #(.N_AGENTS(N_AGENTS)) pick_i (
        .req   (lock_req_i),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign ack_sel = (state_q == QS_STOPPING) ? halt_ack_i : release_ack_i;

    qlk_ack_gather #(.N_AGENTS(N_AGENTS)) gather_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (gather_clr),
        .seed   (seed_oh),
        .enable (collects_acks(state_q)),
        .ack    (ack_sel),
        .all_in (all_in)
    );

    qlk_stop_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == QS_STOPPING),
        .expired (expired)
    );

    assign owner_oh = N_AGENTS'(1) << owner_q;
    assign seed_oh  = N_AGENTS'(1) << owner_d;

    always_comb begin
        state_d    = state_q;
        owner_d    = owner_q;
        grant_d    = '0;
        abort_d    = 1'b0;
        gather_clr = 1'b0;
        unique case (state_q)
            QS_IDLE: if (pick_found) begin
                state_d    = QS_STOPPING;
                owner_d    = pick_idx;
                gather_clr = 1'b1;
            end
            QS_STOPPING: begin
                if (all_in) begin
                    state_d = QS_LOCKED;
                    grant_d = owner_oh;
                end else if (expired) begin
                    state_d    = QS_RESUMING;
                    abort_d    = 1'b1;
                    gather_clr = 1'b1;
                end
            end
            QS_LOCKED: if (unlock_i[owner_q]) begin
                state_d    = QS_RESUMING;
                gather_clr = 1'b1;
            end
            QS_RESUMING: if (all_in) state_d = QS_IDLE;
            default: state_d = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= QS_IDLE;
            owner_q <= '0;
            grant_q <= '0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            grant_q <= grant_d;
            abort_q <= abort_d;
        end
    end

    assign grant_o   = grant_q;
    assign abort_o   = abort_q;
    assign halt_o    = is_quiesced(state_q) ? ~owner_oh : '0;
    assign release_o = (state_q == QS_RESUMING) ? ~owner_oh : '0;
endmodule

// File: rtl/qlk_quiesce_chk.sv
module qlk_quiesce_chk #(
    parameter int N_AGENTS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [N_AGENTS-1:0] grant_o,
    input logic [N_AGENTS-1:0] halt_o,
    input logic [N_AGENTS-1:0] release_o,
    input logic                abort_o
);
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_grant_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (|grant_o) |=> (grant_o == '0));

    p_halt_spares_owner_r2: assert property (@(posedge clk) disable iff (rst)
        (|halt_o) |-> ($countones(halt_o) == N_AGENTS - 1));

    p_grant_while_halted_r6: assert property (@(posedge clk) disable iff (rst)
        (|grant_o) |-> (halt_o == ~grant_o));

    p_halt_release_apart_r7: assert property (@(posedge clk) disable iff (rst)
        !((|halt_o) && (|release_o)));

    p_release_after_halt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(|release_o) |-> $past(|halt_o));

    p_abort_no_grant_r9: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> ((grant_o == '0) && (|release_o)));
endmodule

bind qlk_quiesce_ctrl qlk_quiesce_chk #(.N_AGENTS(N_AGENTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .grant_o   (grant_o),
    .halt_o    (halt_o),
    .release_o (release_o),
    .abort_o   (abort_o)
);

// File: tb/qlk_quiesce_ctrl_tb_top.sv
module qlk_quiesce_ctrl_tb_top;
    localparam int N  = 4;
    localparam int TO = 6;

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] ack;
        logic [1:0] win;
        logic       abort;
    } row_t;

    // req, agents that acknowledge, expected winner, expect abort
    localparam row_t ROWS [8] = '{
        '{4'b0001, 4'b1111, 2'd0, 1'b0},
        '{4'b0100, 4'b1111, 2'd2, 1'b0},
        '{4'b1010, 4'b1111, 2'd1, 1'b0},
        '{4'b1111, 4'b1111, 2'd0, 1'b0},
        '{4'b1000, 4'b1111, 2'd3, 1'b0},
        '{4'b0010, 4'b1101, 2'd1, 1'b0},
        '{4'b0001, 4'b0111, 2'd0, 1'b1},
        '{4'b1100, 4'b0011, 2'd2, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lock_req = '0, unlock = '0, halt_mask = '0, rel_mask = '0;
    logic [N-1:0] grant, halt, release_v, halt_ack, release_ack;
    logic         abort;
    int           errors = 0, checks = 0;
    bit           done = 0;

    always #5 clk = ~clk;

    assign halt_ack    = halt & halt_mask;
    assign release_ack = release_v & rel_mask;

    qlk_quiesce_ctrl #(.N_AGENTS(N), .TIMEOUT_CYCLES(TO)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .lock_req_i    (lock_req),
        .unlock_i      (unlock),
        .grant_o       (grant),
        .halt_o        (halt),
        .halt_ack_i    (halt_ack),
        .release_o     (release_v),
        .release_ack_i (release_ack),
        .abort_o       (abort)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] oh(input int i);
        return N'(1) << i;
    endfunction

    // from a held lock of agent w: unlock and return to idle
    task automatic unlock_and_idle(input int w, input string tag);
        unlock = oh(w);
        rel_mask = '1;
        tick();
        unlock = '0;
        chk(release_v == ~oh(w) && halt == '0, {tag, " R7 release"}, release_v, ~oh(w));
        tick();
        chk(release_v == '0 && halt == '0, {tag, " R7 idle"}, release_v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        chk(grant == '0 && halt == '0 && release_v == '0 && !abort, "R1 reset outputs",
            {grant, halt, release_v}, 0);

        foreach (ROWS[k]) begin
            automatic row_t r = ROWS[k];
            automatic int n = 0;
            automatic bit saw_grant = 0;
            lock_req  = r.req;
            halt_mask = r.ack;
            rel_mask  = '1;
            tick();
            chk(halt == ~oh(r.win), "R2 halt all but requester", halt, ~oh(r.win));
            while (n < TO + 2) begin
                tick();
                n++;
                if (grant != '0) saw_grant = 1;
                if (grant != '0 || abort) break;
            end
            if (!r.abort) begin
                chk(saw_grant && n == 1, "R3 grant after acks", n, 1);
                chk(grant == oh(r.win), "R5 R4 grant winner", grant, oh(r.win));
                lock_req = '0;
                tick();
                chk(grant == '0, "R4 grant single cycle", grant, 0);
                unlock_and_idle(r.win, "row");
            end else begin
                chk(abort && n == TO, "R9 abort timing", n, TO);
                chk(!saw_grant && grant == '0, "R9 no grant", grant, 0);
                chk(release_v == ~oh(r.win), "R9 release after abort", release_v, ~oh(r.win));
                lock_req = '0;
                tick();
                chk(!abort && release_v == '0, "R9 abort pulse back to idle", abort, 0);
            end
        end

        // R10 sticky acknowledge, R3 grant waits for the last ack
        lock_req = 4'b0001;
        halt_mask = 4'b0000;
        tick();
        halt_mask = 4'b0010;
        tick();
        chk(grant == '0, "R3 no grant with partial acks", grant, 0);
        halt_mask = 4'b0000;
        tick();
        chk(grant == '0, "R3 no grant after ack dropped", grant, 0);
        halt_mask = 4'b1100;
        tick();
        chk(grant == 4'b0001, "R10 earlier ack remembered", grant, 1);
        lock_req = '0;
        tick();

        // R6 / R8: locked by agent 0, others try to interfere
        lock_req = 4'b1000;
        unlock = 4'b0100;
        tick();
        tick();
        chk(halt == 4'b1110 && release_v == '0, "R6 foreign unlock ignored", halt, 4'he);
        chk(grant == '0, "R8 request ignored while locked", grant, 0);
        unlock = 4'b0001;
        rel_mask = 4'b0000;
        tick();
        unlock = '0;
        tick();
        chk(release_v == 4'b1110, "R7 release held until acks", release_v, 4'he);
        chk(halt == '0 && grant == '0, "R8 request ignored while resuming", halt, 0);
        rel_mask = 4'b1111;
        tick();
        chk(halt == '0 && release_v == '0, "R7 idle after release acks", halt, 0);
        halt_mask = 4'b1111;
        tick();
        chk(halt == 4'b0111, "R5 waiting loser accepted", halt, 4'h7);
        tick();
        chk(grant == 4'b1000, "R5 loser granted", grant, 4'h8);
        lock_req = '0;
        tick();
        unlock_and_idle(3, "loser");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule